// File: doc/BRIEF.md
# PLL Speed-Up Mode Current Controller

This block produces the digital current settings for the two charge pumps of a phase-locked loop: a proportional pump, which is always active, and an integral pump, which runs only during fast frequency acquisition. It watches the serial programming strobe and the identity of the word being latched. A rising strobe that loads one of the two frequency words starts speed-up mode. In that mode the proportional current is raised by a programmable power of two, and the integral pump is switched on at a programmable multiple of that raised current. When the strobe falls, the loop returns to normal operation at base proportional current with the integral pump off.

The strobe arrives from an unrelated clock domain. It passes through a synchroniser chain before edges are detected. The shift field L and the gain field K are captured when the mode is entered and held for the whole interval. The up and down requests from the phase detector are steered to the pumps as source (raise VCO frequency) and sink (lower VCO frequency) commands. The integral pump only receives them while speed-up is active.

Top module: `spdup_cur_ctrl`

## Requirements
- R1: During and directly after reset, speedup_o is 0, prop_mult_o is 1, int_en_o is 0 and int_mult_o is 0.
- R2: While speed-up is inactive, prop_mult_o stays 1 (base current), int_en_o stays 0 and int_mult_o stays 0.
- R3: A rising strobe while word_id_i equals 1 (word A) or 6 (word A2) sets speedup_o on the third rising clock edge after the strobe changes. The value is still unchanged after the second edge.
- R4: A rising strobe while word_id_i holds any other code leaves speedup_o at 0.
- R5: A falling strobe clears speedup_o on the third rising clock edge after the strobe changes.
- R6: While speed-up is active, prop_mult_o equals 2^(L+1), where L is the 2-bit l_code_i: 2, 4, 8 or 16.
- R7: While speed-up is active, int_en_o is 1 and int_mult_o equals K * 2^(L+1) as an 8-bit value, where K is the 4-bit k_code_i. The largest value is 240.
- R8: L, K and the word identity are sampled on the clock edge that sets speedup_o. Later changes to l_code_i or k_code_i do not alter prop_mult_o or int_mult_o until the next entry.
- R9: prop_up_o follows pd_up_i and prop_dn_o follows pd_dn_i at all times. int_up_o and int_dn_o follow the same requests only while speed-up is active, and are 0 otherwise. Up means source current (VCO frequency to rise); down means sink current (frequency to fall).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Programming strobe, asynchronous |
| word_id_i | input | 3 | Code of the word being latched (1 = A, 6 = A2) |
| l_code_i | input | 2 | Proportional shift field L |
| k_code_i | input | 4 | Integral gain field K |
| pd_up_i | input | 1 | Phase detector request to raise frequency |
| pd_dn_i | input | 1 | Phase detector request to lower frequency |
| speedup_o | output | 1 | Speed-up mode active |
| prop_mult_o | output | 5 | Proportional current multiplier |
| int_en_o | output | 1 | Integral pump enable |
| int_mult_o | output | 8 | Integral current multiplier relative to base |
| prop_up_o | output | 1 | Proportional pump source command |
| prop_dn_o | output | 1 | Proportional pump sink command |
| int_up_o | output | 1 | Integral pump source command |
| int_dn_o | output | 1 | Integral pump sink command |

## Verification
Mode changes reach the outputs three rising clock edges after a strobe change: two synchroniser stages, then the mode register. The bench drives the strobe on a falling edge and samples after two edges to confirm the old value still holds. It samples again after the third edge for the new value. The multipliers come from the same registers as the mode flag, so they are checked in that same sample. The pump direction commands are combinational from the phase detector inputs, and the bench checks them a short delay after driving those inputs within the same low clock phase.

// File: rtl/spdup_pkg.sv
package spdup_pkg;
  localparam int L_W  = 2;
  localparam int K_W  = 4;
  localparam int ID_W = 3;
  localparam int PM_W = (1 << L_W) + 1;
  localparam int IM_W = K_W + PM_W - 1;

  function automatic logic [PM_W-1:0] prop_gain(input logic [L_W-1:0] l);
    logic [PM_W-1:0] r;
    r = '0;
    r[int'(l) + 1] = 1'b1;
    return r;
  endfunction

  function automatic logic [IM_W-1:0] int_gain(input logic [K_W-1:0] k,
                                               input logic [L_W-1:0] l);
    logic [IM_W-1:0] p;
    p = IM_W'(prop_gain(l));
    return IM_W'(k) * p;
  endfunction
endpackage

// File: rtl/spdup_sync_edge.sv
module spdup_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q[0] <= async_i;
      prev_q     <= chain_q[STAGES-1];
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= 1'b0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/spdup_mode.sv
module spdup_mode
  import spdup_pkg::*;
#(
  parameter logic [ID_W-1:0] WORD_A_ID  = 3'd1,
  parameter logic [ID_W-1:0] WORD_A2_ID = 3'd6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic [ID_W-1:0] word_id_i,
  input  logic [L_W-1:0]  l_code_i,
  input  logic [K_W-1:0]  k_code_i,
  output logic            enter_o,
  output logic            active_o,
  output logic [L_W-1:0]  l_q_o,
  output logic [K_W-1:0]  k_q_o
);
  logic id_hit;
  assign id_hit  = (word_id_i == WORD_A_ID) || (word_id_i == WORD_A2_ID);
  assign enter_o = rise_i & id_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      l_q_o    <= '0;
      k_q_o    <= '0;
    end else if (enter_o) begin
      active_o <= 1'b1;
      l_q_o    <= l_code_i;
      k_q_o    <= k_code_i;
    end else if (fall_i) begin
      active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spdup_pump_map.sv
module spdup_pump_map
  import spdup_pkg::*;
(
  input  logic            active_i,
  input  logic [L_W-1:0]  l_q_i,
  input  logic [K_W-1:0]  k_q_i,
  input  logic            pd_up_i,
  input  logic            pd_dn_i,
  output logic [PM_W-1:0] prop_mult_o,
  output logic            int_en_o,
  output logic [IM_W-1:0] int_mult_o,
  output logic            prop_up_o,
  output logic            prop_dn_o,
  output logic            int_up_o,
  output logic            int_dn_o
);
  always_comb begin
    prop_mult_o = active_i ? prop_gain(l_q_i) : PM_W'(1);
    int_mult_o  = active_i ? int_gain(k_q_i, l_q_i) : '0;
  end

  assign int_en_o  = active_i;
  assign prop_up_o = pd_up_i;
  assign prop_dn_o = pd_dn_i;
  assign int_up_o  = pd_up_i & active_i;
  assign int_dn_o  = pd_dn_i & active_i;
endmodule

// File: rtl/spdup_cur_ctrl.sv
module spdup_cur_ctrl
  import spdup_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [ID_W-1:0] WORD_A_ID   = 3'd1,
  parameter logic [ID_W-1:0] WORD_A2_ID  = 3'd6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            strobe_i,
  input  logic [ID_W-1:0] word_id_i,
  input  logic [L_W-1:0]  l_code_i,
  input  logic [K_W-1:0]  k_code_i,
  input  logic            pd_up_i,
  input  logic            pd_dn_i,
  output logic            speedup_o,
  output logic [PM_W-1:0] prop_mult_o,
  output logic            int_en_o,
  output logic [IM_W-1:0] int_mult_o,
  output logic            prop_up_o,
  output logic            prop_dn_o,
  output logic            int_up_o,
  output logic            int_dn_o
);
  logic           rise_evt;
  logic           fall_evt;
  logic           enter_evt;
  logic [L_W-1:0] l_held;
  logic [K_W-1:0] k_held;

  spdup_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(strobe_i),
    .rise_o (rise_evt),
    .fall_o (fall_evt)
  );

  spdup_mode #(.WORD_A_ID(WORD_A_ID), .WORD_A2_ID(WORD_A2_ID)) i_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise_evt),
    .fall_i   (fall_evt),
    .word_id_i(word_id_i),
    .l_code_i (l_code_i),
    .k_code_i (k_code_i),
    .enter_o  (enter_evt),
    .active_o (speedup_o),
    .l_q_o    (l_held),
    .k_q_o    (k_held)
  );

  spdup_pump_map i_map (
    .active_i   (speedup_o),
    .l_q_i      (l_held),
    .k_q_i      (k_held),
    .pd_up_i    (pd_up_i),
    .pd_dn_i    (pd_dn_i),
    .prop_mult_o(prop_mult_o),
    .int_en_o   (int_en_o),
    .int_mult_o (int_mult_o),
    .prop_up_o  (prop_up_o),
    .prop_dn_o  (prop_dn_o),
    .int_up_o   (int_up_o),
    .int_dn_o   (int_dn_o)
  );
endmodule

// File: rtl/spdup_cur_ctrl_chk.sv
module spdup_cur_ctrl_chk
  import spdup_pkg::*;
#(
  parameter logic [ID_W-1:0] WORD_A_ID  = 3'd1,
  parameter logic [ID_W-1:0] WORD_A2_ID = 3'd6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rise_evt,
  input logic            fall_evt,
  input logic [ID_W-1:0] word_id_i,
  input logic            pd_up_i,
  input logic            pd_dn_i,
  input logic            speedup_o,
  input logic [PM_W-1:0] prop_mult_o,
  input logic            int_en_o,
  input logic [IM_W-1:0] int_mult_o,
  input logic            int_up_o,
  input logic            int_dn_o
);
  assert_normal_levels_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !speedup_o |-> (prop_mult_o == PM_W'(1)) && !int_en_o && (int_mult_o == '0));

  assert_entry_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(speedup_o) |-> $past(rise_evt) &&
      (($past(word_id_i) == WORD_A_ID) || ($past(word_id_i) == WORD_A2_ID)));

  assert_other_word_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_evt && !speedup_o && (word_id_i != WORD_A_ID) && (word_id_i != WORD_A2_ID)
      |=> !speedup_o);

  assert_exit_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_evt |=> !speedup_o);

  assert_prop_power_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speedup_o |-> ($countones(prop_mult_o) == 1) && (prop_mult_o != PM_W'(1)));

  assert_int_enabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speedup_o |-> int_en_o);

  assert_fields_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speedup_o && $past(speedup_o) |-> $stable(prop_mult_o) && $stable(int_mult_o));

  assert_int_dir_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_o |-> !int_up_o && !int_dn_o);

  assert_int_dir_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_en_o |-> (int_up_o == pd_up_i) && (int_dn_o == pd_dn_i));
endmodule

bind spdup_cur_ctrl spdup_cur_ctrl_chk #(
  .WORD_A_ID (WORD_A_ID),
  .WORD_A2_ID(WORD_A2_ID)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt),
  .word_id_i  (word_id_i),
  .pd_up_i    (pd_up_i),
  .pd_dn_i    (pd_dn_i),
  .speedup_o  (speedup_o),
  .prop_mult_o(prop_mult_o),
  .int_en_o   (int_en_o),
  .int_mult_o (int_mult_o),
  .int_up_o   (int_up_o),
  .int_dn_o   (int_dn_o)
);

// File: tb/test_spdup_cur_ctrl.sv
`timescale 1ns/1ps
module test_spdup_cur_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strobe_i = 1'b0;
  logic [2:0] word_id_i = '0;
  logic [1:0] l_code_i = '0;
  logic [3:0] k_code_i = '0;
  logic       pd_up_i = 1'b0;
  logic       pd_dn_i = 1'b0;
  logic       speedup_o;
  logic [4:0] prop_mult_o;
  logic       int_en_o;
  logic [7:0] int_mult_o;
  logic       prop_up_o, prop_dn_o, int_up_o, int_dn_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit model_on = 0;
  int model_l = 0;
  int model_k = 0;

  always #2.5 clk_i = ~clk_i;

  spdup_cur_ctrl i_spdup_cur_ctrl (.*);

  function automatic int exp_prop(input int on, input int l);
    int m;
    if (on == 0) return 1;
    m = 1;
    for (int i = 0; i <= l; i++) m = m * 2;
    return m;
  endfunction

  function automatic int exp_int(input int on, input int l, input int k);
    if (on == 0) return 0;
    return k * exp_prop(1, l);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    chk({req, " mode"}, int'(speedup_o), int'(model_on));
    chk({req, " prop"}, int'(prop_mult_o), exp_prop(int'(model_on), model_l));
    chk({req, " int_en"}, int'(int_en_o), int'(model_on));
    chk({req, " int"}, int'(int_mult_o), exp_int(int'(model_on), model_l, model_k));
  endtask

  // drive at a falling edge, check old value after two rising edges, new after three
  task automatic move_strobe(input logic val, input bit expect_on, input string req);
    @(negedge clk_i);
    strobe_i = val;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk({req, " latency hold"}, int'(speedup_o), int'(model_on));
    @(posedge clk_i);
    @(negedge clk_i);
    if (expect_on && !model_on) begin
      model_l = int'(l_code_i);
      model_k = int'(k_code_i);
    end
    model_on = expect_on;
    chk_outputs(req);
  endtask

  task automatic chk_dir(input logic up, input logic dn);
    @(negedge clk_i);
    pd_up_i = up;
    pd_dn_i = dn;
    #1;
    chk("R9 prop up", int'(prop_up_o), int'(up));
    chk("R9 prop dn", int'(prop_dn_o), int'(dn));
    chk("R9 int up", int'(int_up_o), int'(up & model_on));
    chk("R9 int dn", int'(int_dn_o), int'(dn & model_on));
  endtask

  task automatic interval(input logic [2:0] id, input logic [1:0] l, input logic [3:0] k);
    bit hit;
    hit = (id == 3'd1) || (id == 3'd6);
    @(negedge clk_i);
    word_id_i = id;
    l_code_i  = l;
    k_code_i  = k;
    if (hit) move_strobe(1'b1, 1'b1, "R3 R6 R7 entry");
    else     move_strobe(1'b1, 1'b0, "R4 other word");
    // R8: change fields while strobe is high
    @(negedge clk_i);
    l_code_i = l_code_i + 2'd1;
    k_code_i = k_code_i ^ 4'hF;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk_outputs("R8 frozen");
    chk_dir(1'b1, 1'b0);
    chk_dir(1'b0, 1'b1);
    move_strobe(1'b0, 1'b0, "R5 R2 exit");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk_outputs("R1 in reset");
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk_outputs("R1 after reset");
    chk_dir(1'b1, 1'b0);
    // directed corners
    interval(3'd1, 2'd3, 4'd15);   // 240
    interval(3'd6, 2'd0, 4'd1);    // x2, x2
    interval(3'd6, 2'd2, 4'd0);    // K=0
    interval(3'd0, 2'd3, 4'd15);   // R4
    interval(3'd7, 2'd1, 4'd5);    // R4
    for (int it = 0; it < 40; it++) begin
      logic [2:0] id;
      id = ($urandom % 3 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'd1 : 3'd6);
      interval(id, 2'($urandom), 4'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule